// File: doc/BRIEF.md
# Two-Stage SCL Bit-Rate Divider

This block turns the module clock of an I2C controller into the timing strobes that the protocol engine needs for each SCL bit. No derived clock is made: everything stays in the module clock domain as single-cycle enables. A prescaler first produces an internal tick every (P+1) module clocks, with P from a 2-bit field. A position counter then counts those ticks through one SCL period of 8*G + 20 ticks, with G from a 6-bit field.

The counter state drives a low-phase flag and a high-phase flag. It also drives a sample strobe three quarters of the way through the period, which is the middle of the high phase, and an end-of-period strobe. Both fields come from one 8-bit configuration word. A new word is staged and only becomes active at a period boundary, or at once while the engine is idle. The running SCL waveform is therefore never cut short by a reconfiguration.

Top module: `scl_clk_div`

## Requirements
- R1: While `run` is low (and in reset) all four outputs are 0 and both counters are held at their start position. After reset the active configuration is P=0, G=0.
- R2: In the configuration word, bits [1:0] hold the prescale value P and bits [7:2] hold the period code G.
- R3: Counting from the first cycle with `run` high, the internal tick occurs every P+1 module clocks. One SCL period lasts (P+1)*(8*G+20) module clocks, and consecutive `period_stb` pulses are that far apart.
- R4: While running, with N = 8*G+20, the first ceil(N/2) internal ticks of every period are in the low phase and the rest are in the high phase. Exactly one of `scl_low_ph` and `scl_high_ph` is 1 at any time, and a new period starts in the low phase.
- R5: `sample_stb` is 1 for exactly one module clock per period, on the tick at period position 6*G+15 (three quarters of N). This position lies inside the high phase.
- R6: `period_stb` is 1 for exactly one module clock per period, on the last module clock of the period's last tick.
- R7: A word written while running is held pending and becomes active for the period that follows the current one. A word written in the boundary cycle itself applies to the very next period.
- R8: A word written while idle is active from the first period after `run` rises.
- R9: A period code of 63 is treated as 62, the largest valid code, so N = 516.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Engine active; low holds the divider idle |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration word: [1:0] prescale P, [7:2] period code G |
| scl_low_ph | output | 1 | SCL low phase in progress |
| scl_high_ph | output | 1 | SCL high phase in progress |
| sample_stb | output | 1 | One-cycle sample strobe in the middle of the high phase |
| period_stb | output | 1 | One-cycle strobe on the last module clock of a period |

## Verification
The period code is swept over all 64 values with no prescale. Each sweep point checks the phase split, the sample position and the period length cycle by cycle, so an error in the step of 8, the offset of 20 or the saturation of code 63 is caught. A subset of codes is repeated with every prescale value, so a wrong prescale count is separated from a wrong position count. Reconfigurations are made mid-period, in the boundary cycle and while idle. The resulting strobe spacing shows whether a word takes effect too early, too late, or at the right edge.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;

    localparam int PRE_W    = 2;
    localparam int DIV_W    = 6;
    localparam int CFG_W    = PRE_W + DIV_W;
    localparam int STEP_SH  = 3;
    localparam int PER_BASE = 20;
    localparam int DIV_MAX  = (1 << DIV_W) - 2;
    localparam int PER_MAX  = (DIV_MAX << STEP_SH) + PER_BASE;
    localparam int CNT_W    = $clog2(PER_MAX + 1);

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [PRE_W-1:0] pre;
    } div_cfg_t;

    function automatic div_cfg_t cfg_decode(input logic [CFG_W-1:0] raw);
        div_cfg_t c;
        c = div_cfg_t'(raw);
        if (c.div > DIV_W'(DIV_MAX))
            c.div = DIV_W'(DIV_MAX);
        return c;
    endfunction

    function automatic logic [CNT_W-1:0] period_len(input logic [DIV_W-1:0] d);
        return CNT_W'({d, {STEP_SH{1'b0}}}) + CNT_W'(PER_BASE);
    endfunction

endpackage

// File: rtl/scl_cfg_hold.sv
module scl_cfg_hold
    import scl_div_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             boundary,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output div_cfg_t         active
);
    logic [CFG_W-1:0] pending;
    logic [CFG_W-1:0] pending_nx;

    assign pending_nx = we ? wdata : pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= '0;
            active  <= '0;
        end else begin
            pending <= pending_nx;
            if (!run || boundary)
                active <= cfg_decode(pending_nx);
        end
    end
endmodule

// File: rtl/scl_prescale.sv
module scl_prescale
    import scl_div_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [PRE_W-1:0] pre_div,
    output logic             itick
);
    logic [PRE_W-1:0] cnt;

    assign itick = run && (cnt == pre_div);

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (itick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen
    import scl_div_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             itick,
    input  logic [DIV_W-1:0] div,
    output logic             low_ph,
    output logic             high_ph,
    output logic             sample,
    output logic             boundary
);
    logic [CNT_W-1:0] pos;
    logic [CNT_W-1:0] per_len;
    logic [CNT_W-1:0] low_len;
    logic [CNT_W-1:0] samp_pos;
    logic             last;
    logic             in_low;

    assign per_len  = period_len(div);
    assign low_len  = (per_len + CNT_W'(1)) >> 1;
    assign samp_pos = (per_len >> 1) + (per_len >> 2);
    assign last     = (pos == per_len - CNT_W'(1));
    assign in_low   = (pos < low_len);

    assign low_ph   = run && in_low;
    assign high_ph  = run && !in_low;
    assign sample   = itick && (pos == samp_pos);
    assign boundary = itick && last;

    always_ff @(posedge clk) begin
        if (rst || !run)
            pos <= '0;
        else if (itick)
            pos <= last ? '0 : pos + CNT_W'(1);
    end
endmodule

// File: rtl/scl_clk_div.sv
module scl_clk_div
    import scl_div_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic             scl_low_ph,
    output logic             scl_high_ph,
    output logic             sample_stb,
    output logic             period_stb
);
    div_cfg_t act_cfg;
    logic     itick;
    logic     boundary;

    scl_cfg_hold u_cfg (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .boundary (boundary),
        .we       (cfg_we),
        .wdata    (cfg_wdata),
        .active   (act_cfg)
    );

    scl_prescale u_pre (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .pre_div (act_cfg.pre),
        .itick   (itick)
    );

    scl_phase_gen u_phase (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .itick    (itick),
        .div      (act_cfg.div),
        .low_ph   (scl_low_ph),
        .high_ph  (scl_high_ph),
        .sample   (sample_stb),
        .boundary (boundary)
    );

    assign period_stb = boundary;
endmodule

// File: rtl/scl_clk_div_chk.sv
module scl_clk_div_chk
    import scl_div_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             run,
    input logic             cfg_we,
    input logic [CFG_W-1:0] cfg_wdata,
    input logic             scl_low_ph,
    input logic             scl_high_ph,
    input logic             sample_stb,
    input logic             period_stb
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !run |-> !(scl_low_ph || scl_high_ph || sample_stb || period_stb));

    p_one_phase_r4: assert property (@(posedge clk) disable iff (rst)
        run |-> ($countones({scl_low_ph, scl_high_ph}) == 1));

    p_wrap_low_r4: assert property (@(posedge clk) disable iff (rst)
        (run && period_stb) |=> (!run || scl_low_ph));

    p_sample_high_r5: assert property (@(posedge clk) disable iff (rst)
        sample_stb |-> scl_high_ph);

    p_sample_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        sample_stb |=> !sample_stb);

    p_end_high_r6: assert property (@(posedge clk) disable iff (rst)
        period_stb |-> scl_high_ph);

    p_end_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        period_stb |=> !period_stb);
endmodule

bind scl_clk_div scl_clk_div_chk u_chk (.*);

// File: tb/test_scl_clk_div.sv
`timescale 1ns/1ps
module test_scl_clk_div;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       run = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'd0;
    logic       scl_low_ph, scl_high_ph, sample_stb, period_stb;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // bench model state
    int mpre = 0, mcnt = 0, mp = 0, mg = 0;
    logic [7:0] mpend = 8'd0;
    int since_run = 0;
    int ends[4];
    int nends = 0;

    always #2.5 clk = ~clk;

    scl_clk_div i_scl_clk_div (
        .clk(clk), .rst(rst), .run(run), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .scl_low_ph(scl_low_ph), .scl_high_ph(scl_high_ph),
        .sample_stb(sample_stb), .period_stb(period_stb)
    );

    function automatic int sat(input int g);
        return (g > 62) ? 62 : g;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp_v);
        n_chk++;
        if (act != exp_v) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp_v);
        end
    endtask

    task automatic cyc(input logic r, input logic we, input logic [7:0] d);
        int n, it, bnd, nxp, nxc;
        logic [7:0] np;
        run = r; cfg_we = we; cfg_wdata = d;
        #1;
        n   = 8 * mg + 20;
        it  = (r && mpre == mp) ? 1 : 0;
        bnd = (it && mcnt == n - 1) ? 1 : 0;
        chk("R4", "low phase",  int'(scl_low_ph),  (r && mcnt <  (n + 1) / 2) ? 1 : 0);
        chk("R4", "high phase", int'(scl_high_ph), (r && mcnt >= (n + 1) / 2) ? 1 : 0);
        chk("R5", "sample strobe", int'(sample_stb), (it && mcnt == 6 * mg + 15) ? 1 : 0);
        chk("R6", "period strobe", int'(period_stb), bnd);
        if (period_stb && nends < 4) begin
            ends[nends] = since_run;
            nends++;
        end
        @(posedge clk);
        np  = we ? d : mpend;
        nxp = !r ? 0 : (it ? 0 : mpre + 1);
        nxc = !r ? 0 : (it ? (bnd ? 0 : mcnt + 1) : mcnt);
        if (!r || bnd) begin
            mp = int'(np[1:0]);
            mg = sat(int'(np[7:2]));
        end
        mpend = np; mpre = nxp; mcnt = nxc;
        since_run = r ? since_run + 1 : 0;
        @(negedge clk);
    endtask

    // configure while idle (R8), run for a number of periods, check spacing (R3)
    task automatic run_cfg(input int p, input int g, input int periods);
        int len;
        len = (p + 1) * (8 * sat(g) + 20);
        cyc(1'b0, 1'b1, 8'((g << 2) | p));
        cyc(1'b0, 1'b0, 8'd0);
        nends = 0;
        for (int i = 0; i < periods * len + 2; i++) cyc(1'b1, 1'b0, 8'd0);
        chk("R8", "first end after idle write", ends[0], len - 1);
        if (periods > 1)
            chk("R3", "period spacing", ends[1] - ends[0], len);
        cyc(1'b0, 1'b0, 8'd0);
        chk("R1", "idle outputs", int'({scl_low_ph, scl_high_ph, sample_stb, period_stb}), 0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        for (int i = 0; i < 4; i++) @(negedge clk);
        #1;
        chk("R1", "outputs in reset", int'({scl_low_ph, scl_high_ph, sample_stb, period_stb}), 0);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset configuration P=0 G=0 gives a 20-clock period
        nends = 0;
        for (int i = 0; i < 45; i++) cyc(1'b1, 1'b0, 8'd0);
        chk("R1", "reset config period", ends[0], 19);
        chk("R3", "reset config spacing", ends[1] - ends[0], 20);
        cyc(1'b0, 1'b0, 8'd0);

        // R2: word 0b000001_10 means P=2, G=1 -> 3*28 = 84 clocks
        run_cfg(2, 1, 2);
        chk("R2", "field position", ends[0], 83);

        // full sweep of period code with no prescale
        for (int g = 0; g < 64; g++) run_cfg(0, g, 1);

        // R9: code 63 saturates to 62
        run_cfg(0, 63, 1);
        chk("R9", "code 63 period", ends[0], 515);

        // prescale sweep on a subset of codes (R3)
        for (int p = 1; p < 4; p++) begin
            run_cfg(p, 0, 2);
            run_cfg(p, 1, 2);
            run_cfg(p, 7, 2);
            run_cfg(p, 62, 2);
        end

        // R7: mid-period write defers to the next period
        cyc(1'b0, 1'b1, 8'((2 << 2) | 1));   // P=1, G=2: 72 clocks
        nends = 0;
        for (int i = 0; i < 10; i++) cyc(1'b1, 1'b0, 8'd0);
        cyc(1'b1, 1'b1, 8'd0);               // P=0, G=0: 20 clocks
        for (int i = 0; i < 120; i++) cyc(1'b1, 1'b0, 8'd0);
        chk("R7", "old period kept", ends[0], 71);
        chk("R7", "new period after boundary", ends[1], 91);
        cyc(1'b0, 1'b0, 8'd0);

        // R7: write in the boundary cycle applies to the next period
        cyc(1'b0, 1'b1, 8'd0);               // P=0, G=0
        nends = 0;
        for (int i = 0; i < 19; i++) cyc(1'b1, 1'b0, 8'd0);
        cyc(1'b1, 1'b1, 8'(1 << 2));         // G=1 -> 28
        for (int i = 0; i < 40; i++) cyc(1'b1, 1'b0, 8'd0);
        chk("R7", "boundary write end 0", ends[0], 19);
        chk("R7", "boundary write end 1", ends[1], 47);
        cyc(1'b0, 1'b0, 8'd0);
        chk("R1", "idle after run", int'({scl_low_ph, scl_high_ph, sample_stb, period_stb}), 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule